// File: doc/BRIEF.md
# Receive Element Writer for a Flexible-Data-Rate CAN Controller

This block stores frames that have already been received into a receive queue. The queue lives in a word-addressed message memory. Each frame arrives in two parts: a header handshake, and then a byte stream. The header carries the identifier, the format, rate-switch and error-state flags, the extended-identifier flag and the length code. The block turns the length code into a payload length. The mapping is non-linear for flexible-data-rate frames.

The block writes one queue element per frame. An element is two header words followed by the payload, packed into 32-bit words. Every element has the same fixed footprint, chosen by a size setting. Payload bytes that do not fit in that footprint are consumed from the stream and dropped without any error flag. The write index moves on only once the whole frame has been handled. A consumer frees elements with a pop strobe.

When the queue is full, the arriving frame is consumed and discarded, and a sticky overrun flag is raised. Message filtering and bit-level reception happen elsewhere.

Top module: `rxq_elem_writer`

## Requirements
- R1: Length codes 0 to 8 give that many payload bytes. For a frame with the format flag set, codes 9, 10, 11, 12, 13, 14 and 15 give 12, 16, 20, 24, 32, 48 and 64 bytes.
- R2: For a frame with the format flag clear, any length code above 8 gives 8 payload bytes, and the stream carries exactly 8 bytes.
- R3: The size setting `cfg_esz` values 0, 1, 2 and 3 give a capacity of 8, 16, 32 and 64 bytes. An element occupies 2 header words plus capacity/4 data words (2 + 2, 4, 8 or 16 words). Element i starts at `cfg_base + i * words_per_element`. No write falls outside the element being filled.
- R4: Header word 0 (element offset 0) holds the identifier in bits 28:0, 0 in bit 29, the extended flag in bit 30 and the error-state flag in bit 31. Header word 1 (offset 1) holds the length code in bits 3:0, the rate-switch flag in bit 4, the format flag in bit 5, and the stored byte count in bits 14:8. All its other bits are 0.
- R5: Payload byte k goes to data word k/4 (element offset 2 + k/4), in bits 8*(k%4)+7 down to 8*(k%4). Only words holding stored bytes are written. Unused upper bytes of the last written word are 0.
- R6: Bytes beyond the capacity are still accepted from the stream but are not written. No flag is set, and the stored byte count is min(length, capacity).
- R7: `put_idx` advances by one on the clock edge that completes the frame: the last byte accepted, or the second header word for a zero-length frame. It wraps to 0 at `cfg_count`.
- R8: A header accepted while `fifo_full` is high writes nothing and leaves `put_idx` unchanged. The frame's bytes are still consumed, and `overrun` is set and stays set until reset.
- R9: `pop` with a non-zero `fill` advances `get_idx` (wrapping at `cfg_count`) and lowers `fill`. `pop` with `fill` equal to 0 has no effect. `fifo_full` is high when `fill` equals `cfg_count`.
- R10: After reset, `put_idx`, `get_idx` and `fill` are 0, `overrun` and `ram_we` are low, and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Word address of element 0 |
| cfg_count | input | CW | Number of elements in the queue (1..MAX_ELEMS) |
| cfg_esz | input | 2 | Element payload capacity code |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Block idle and able to take a header |
| hdr_id | input | 29 | Frame identifier |
| hdr_xtd | input | 1 | Extended identifier flag |
| hdr_fdf | input | 1 | Flexible-data-rate format flag |
| hdr_brs | input | 1 | Rate-switch flag |
| hdr_esi | input | 1 | Error-state flag |
| hdr_dlc | input | 4 | Length code |
| dat_valid | input | 1 | Payload byte offered |
| dat_ready | output | 1 | Block consuming payload bytes |
| dat_byte | input | 8 | Payload byte |
| ram_we | output | 1 | Message memory write strobe |
| ram_addr | output | AW | Message memory word address |
| ram_wdata | output | 32 | Message memory write data |
| pop | input | 1 | Consumer releases the oldest element |
| put_idx | output | IW | Next element to be written |
| get_idx | output | IW | Oldest unreleased element |
| fill | output | CW | Number of stored elements |
| fifo_full | output | 1 | Queue holds cfg_count elements |
| overrun | output | 1 | Sticky: a frame was discarded |

## Verification
A wrong byte counter or length decode shows up at the memory port within one cycle. A write appears on the wrong lane or at the wrong offset, or a write is missing, and the write ends in a different cycle from the one the bench predicts. A corrupt index or fill count is not visible in the write data. It shows in the element base address of the next frame, or in `fifo_full` and `overrun` a few frames later. The bench therefore checks every write address and the index outputs after each frame and each pop.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  localparam int HDR_WORDS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_DATA,
    ST_DROP
  } wr_state_e;

  // payload length carried by a frame, from its length code
  function automatic logic [6:0] dlc_bytes(input logic [3:0] dlc, input logic fdf);
    logic [6:0] n;
    if (dlc <= 4'd8)   n = {3'd0, dlc};
    else if (!fdf)     n = 7'd8;
    else begin
      case (dlc)
        4'd9:    n = 7'd12;
        4'd10:   n = 7'd16;
        4'd11:   n = 7'd20;
        4'd12:   n = 7'd24;
        4'd13:   n = 7'd32;
        4'd14:   n = 7'd48;
        default: n = 7'd64;
      endcase
    end
    return n;
  endfunction

  // payload capacity of one element
  function automatic logic [6:0] esz_bytes(input logic [1:0] esz);
    return 7'd8 << esz;
  endfunction

  // total footprint of one element in words
  function automatic logic [4:0] esz_words(input logic [1:0] esz);
    return 5'(HDR_WORDS) + (5'd2 << esz);
  endfunction

  function automatic logic [31:0] hdr_word0(input logic [28:0] id,
                                            input logic xtd, input logic esi);
    return {esi, xtd, 1'b0, id};
  endfunction

  function automatic logic [31:0] hdr_word1(input logic [3:0] dlc, input logic brs,
                                            input logic fdf, input logic [6:0] stored);
    return {17'd0, stored, 2'b00, fdf, brs, dlc};
  endfunction

endpackage

// File: rtl/rxq_len_calc.sv
`timescale 1ns/1ps
module rxq_len_calc
  import rxq_pkg::*;
(
  input  logic [3:0] dlc,
  input  logic       fdf,
  input  logic [1:0] esz,
  output logic [6:0] frame_len,
  output logic [6:0] store_len
);

  logic [6:0] cap;

  assign frame_len = dlc_bytes(dlc, fdf);
  assign cap       = esz_bytes(esz);
  assign store_len = (frame_len > cap) ? cap : frame_len;

endmodule

// File: rtl/rxq_elem_addr.sv
`timescale 1ns/1ps
module rxq_elem_addr
  import rxq_pkg::*;
#(
  parameter int AW = 12,
  parameter int IW = 4
) (
  input  logic [AW-1:0] cfg_base,
  input  logic [1:0]    cfg_esz,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] elem_base,
  output logic [4:0]    elem_words
);

  assign elem_words = esz_words(cfg_esz);
  assign elem_base  = cfg_base + (AW'(idx) * AW'(elem_words));

endmodule

// File: rtl/rxq_word_pack.sv
`timescale 1ns/1ps
module rxq_word_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word
);

  logic [7:0] held_q [3];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    if (g < 3) begin : g_hold
      always_ff @(posedge clk) begin
        if (!rst_n)                      held_q[g] <= 8'h00;
        else if (load && lane == 2'(g))  held_q[g] <= din;
      end
      assign word[8*g +: 8] = (lane == 2'(g)) ? din :
                              (lane > 2'(g))  ? held_q[g] : 8'h00;
    end else begin : g_top
      assign word[8*g +: 8] = (lane == 2'(g)) ? din : 8'h00;
    end
  end

endmodule

// File: rtl/rxq_index_ctl.sv
`timescale 1ns/1ps
module rxq_index_ctl #(
  parameter int MAX_ELEMS = 16,
  parameter int IW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_count,
  input  logic          commit,
  input  logic          pop,
  input  logic          drop,
  output logic [IW-1:0] put_idx,
  output logic [IW-1:0] get_idx,
  output logic [CW-1:0] fill,
  output logic          fifo_full,
  output logic          overrun
);

  logic [IW-1:0] put_q, get_q;
  logic [CW-1:0] fill_q;
  logic          ovr_q;
  logic          pop_ok;
  logic [CW-1:0] put_inc, get_inc;

  assign pop_ok  = pop && (fill_q != '0);
  assign put_inc = CW'(put_q) + CW'(1);
  assign get_inc = CW'(get_q) + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      put_q  <= '0;
      get_q  <= '0;
      fill_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (commit) put_q <= (put_inc >= cfg_count) ? '0 : put_inc[IW-1:0];
      if (pop_ok) get_q <= (get_inc >= cfg_count) ? '0 : get_inc[IW-1:0];
      case ({commit, pop_ok})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
      if (drop) ovr_q <= 1'b1;
    end
  end

  assign put_idx   = put_q;
  assign get_idx   = get_q;
  assign fill      = fill_q;
  assign fifo_full = (fill_q >= cfg_count);
  assign overrun   = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fill_q <= cfg_count); // R9
  AST_PUT_WRAP:    assert property (@(posedge clk) disable iff (!rst_n) CW'(put_q) < cfg_count); // R7
  AST_PUT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !commit |=> $stable(put_q)); // R7
  AST_GET_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !pop |=> $stable(get_q)); // R9
  AST_OVR_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) ovr_q |=> ovr_q); // R8
  AST_FULL_DROP:   assert property (@(posedge clk) disable iff (!rst_n) drop |=> ovr_q && $stable(put_q)); // R8

endmodule

// File: rtl/rxq_elem_writer.sv
`timescale 1ns/1ps
module rxq_elem_writer
  import rxq_pkg::*;
#(
  parameter int AW = 12,
  parameter int MAX_ELEMS = 16,
  localparam int IW = $clog2(MAX_ELEMS),
  localparam int CW = $clog2(MAX_ELEMS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_esz,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [28:0]   hdr_id,
  input  logic          hdr_xtd,
  input  logic          hdr_fdf,
  input  logic          hdr_brs,
  input  logic          hdr_esi,
  input  logic [3:0]    hdr_dlc,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [7:0]    dat_byte,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [31:0]   ram_wdata,
  input  logic          pop,
  output logic [IW-1:0] put_idx,
  output logic [IW-1:0] get_idx,
  output logic [CW-1:0] fill,
  output logic          fifo_full,
  output logic          overrun
);

  wr_state_e state_q, state_d;

  logic [28:0] id_q;
  logic        xtd_q, fdf_q, brs_q, esi_q;
  logic [3:0]  dlc_q;
  logic [6:0]  flen_q, slen_q, bcnt_q;
  logic [6:0]  flen_in, slen_in;

  // named internal events
  logic hdr_acc, drop_evt, byte_acc, keep_byte, last_byte, word_done, commit;
  logic [AW-1:0] elem_base;
  logic [4:0]    elem_words;
  logic [4:0]    woff;
  logic [31:0]   pack_word;

  rxq_len_calc u_len (
    .dlc       (hdr_dlc),
    .fdf       (hdr_fdf),
    .esz       (cfg_esz),
    .frame_len (flen_in),
    .store_len (slen_in)
  );

  rxq_elem_addr #(.AW(AW), .IW(IW)) u_addr (
    .cfg_base   (cfg_base),
    .cfg_esz    (cfg_esz),
    .idx        (put_idx),
    .elem_base  (elem_base),
    .elem_words (elem_words)
  );

  rxq_word_pack u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (byte_acc && keep_byte),
    .lane  (bcnt_q[1:0]),
    .din   (dat_byte),
    .word  (pack_word)
  );

  rxq_index_ctl #(.MAX_ELEMS(MAX_ELEMS), .IW(IW), .CW(CW)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_count (cfg_count),
    .commit    (commit),
    .pop       (pop),
    .drop      (drop_evt),
    .put_idx   (put_idx),
    .get_idx   (get_idx),
    .fill      (fill),
    .fifo_full (fifo_full),
    .overrun   (overrun)
  );

  assign hdr_ready = (state_q == ST_IDLE);
  assign dat_ready = (state_q == ST_DATA) || (state_q == ST_DROP);
  assign hdr_acc   = hdr_valid && hdr_ready;
  assign drop_evt  = hdr_acc && fifo_full;
  assign byte_acc  = dat_valid && dat_ready;
  assign keep_byte = (state_q == ST_DATA) && (bcnt_q < slen_q);
  assign last_byte = byte_acc && (bcnt_q == flen_q - 7'd1);
  assign word_done = byte_acc && keep_byte &&
                     ((bcnt_q[1:0] == 2'd3) || (bcnt_q == slen_q - 7'd1));
  assign commit    = ((state_q == ST_HDR1) && (flen_q == 7'd0)) ||
                     ((state_q == ST_DATA) && last_byte);

  always_comb begin
    case (state_q)
      ST_HDR0: woff = 5'd0;
      ST_HDR1: woff = 5'd1;
      default: woff = 5'(HDR_WORDS) + 5'(bcnt_q[6:2]);
    endcase
  end

  assign ram_we   = (state_q == ST_HDR0) || (state_q == ST_HDR1) || word_done;
  assign ram_addr = elem_base + AW'(woff);

  always_comb begin
    case (state_q)
      ST_HDR0: ram_wdata = hdr_word0(id_q, xtd_q, esi_q);
      ST_HDR1: ram_wdata = hdr_word1(dlc_q, brs_q, fdf_q, slen_q);
      default: ram_wdata = pack_word;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (hdr_acc) begin
        if (fifo_full) state_d = (flen_in == 7'd0) ? ST_IDLE : ST_DROP;
        else           state_d = ST_HDR0;
      end
      ST_HDR0: state_d = ST_HDR1;
      ST_HDR1: state_d = (flen_q == 7'd0) ? ST_IDLE : ST_DATA;
      ST_DATA: if (last_byte) state_d = ST_IDLE;
      ST_DROP: if (last_byte) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      xtd_q   <= 1'b0;
      fdf_q   <= 1'b0;
      brs_q   <= 1'b0;
      esi_q   <= 1'b0;
      dlc_q   <= '0;
      flen_q  <= '0;
      slen_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (hdr_acc) begin
        id_q   <= hdr_id;
        xtd_q  <= hdr_xtd;
        fdf_q  <= hdr_fdf;
        brs_q  <= hdr_brs;
        esi_q  <= hdr_esi;
        dlc_q  <= hdr_dlc;
        flen_q <= flen_in;
        slen_q <= slen_in;
        bcnt_q <= '0;
      end else if (byte_acc) begin
        bcnt_q <= bcnt_q + 7'd1;
      end
    end
  end

  AST_WRITE_IN_ELEM:  assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> (ram_addr - elem_base) < AW'(elem_words)); // R3
  AST_DROP_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_DROP) |-> !ram_we); // R8
  AST_TRUNC_SILENT:   assert property (@(posedge clk) disable iff (!rst_n) (byte_acc && state_q == ST_DATA && !keep_byte) |-> !ram_we && !drop_evt); // R6
  AST_COMMIT_ONCE:    assert property (@(posedge clk) disable iff (!rst_n) commit |=> hdr_ready); // R7
  AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> hdr_ready && !ram_we); // R10

endmodule

// File: tb/rxq_elem_writer_test.sv
`timescale 1ns/1ps
module rxq_elem_writer_test;

  localparam int AW = 12;
  localparam int MAXE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_base = '0;
  logic [4:0]  cfg_count = 5'd4;
  logic [1:0]  cfg_esz = '0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [28:0] hdr_id = '0;
  logic        hdr_xtd = 1'b0, hdr_fdf = 1'b0, hdr_brs = 1'b0, hdr_esi = 1'b0;
  logic [3:0]  hdr_dlc = '0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [7:0]  dat_byte = '0;
  logic        ram_we;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata;
  logic        pop = 1'b0;
  logic [3:0]  put_idx, get_idx;
  logic [4:0]  fill;
  logic        fifo_full, overrun;

  rxq_elem_writer #(.AW(AW), .MAX_ELEMS(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_count(cfg_count), .cfg_esz(cfg_esz),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_id(hdr_id), .hdr_xtd(hdr_xtd),
    .hdr_fdf(hdr_fdf), .hdr_brs(hdr_brs), .hdr_esi(hdr_esi), .hdr_dlc(hdr_dlc),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .pop(pop),
    .put_idx(put_idx), .get_idx(get_idx), .fill(fill), .fifo_full(fifo_full), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R5";

  // reference model state
  int m_put, m_get, m_fill, m_count, m_base, m_esz;
  bit m_ovr;
  int exp_addr[$];
  int exp_data[$];
  int fd_len[7] = '{12, 16, 20, 24, 32, 48, 64};

  function automatic int ref_len(int dlc, bit fdf);
    if (dlc <= 8) return dlc;
    if (!fdf) return 8;
    return fd_len[dlc - 9];
  endfunction

  function automatic int pbyte(int seed, int k);
    return (seed * 7 + k * 29 + 3) % 256;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // every clock: each memory write must be the next one the model predicts
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_addr.size() == 0) begin
        chk("R3", "unexpected write addr", int'(ram_addr), -1);
      end else begin
        chk(cur_tag, "write addr", int'(ram_addr), exp_addr.pop_front());
        chk(cur_tag, "write data", int'(ram_wdata), exp_data.pop_front());
      end
    end
  end

  task automatic check_state(string tag);
    chk(tag, "put_idx", int'(put_idx), m_put);
    chk(tag, "get_idx", int'(get_idx), m_get);
    chk(tag, "fill", int'(fill), m_fill);
    chk(tag, "fifo_full", int'(fifo_full), int'(m_fill == m_count));
    chk(tag, "overrun", int'(overrun), int'(m_ovr));
  endtask

  task automatic start(int base, int count, int esz);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_base = 12'(base); cfg_count = 5'(count); cfg_esz = 2'(esz);
    m_put = 0; m_get = 0; m_fill = 0; m_ovr = 0;
    m_count = count; m_base = base; m_esz = esz;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_state("R10");
    chk("R10", "ram_we", int'(ram_we), 0);
    chk("R10", "hdr_ready", int'(hdr_ready), 1);
  endtask

  task automatic send_frame(string tag, int id, bit xtd, bit fdf, bit brs, bit esi,
                            int dlc, int seed);
    int n, cap, st, wpe, a0, w1;
    bit dropped, r;
    n = ref_len(dlc, fdf);
    cap = 8 * (1 << m_esz);
    st = (n < cap) ? n : cap;
    wpe = 2 + cap / 4;
    cur_tag = tag;
    dropped = (m_fill == m_count);
    if (!dropped) begin
      a0 = m_base + m_put * wpe;
      exp_addr.push_back(a0);
      exp_data.push_back({esi, xtd, 1'b0, 29'(id)});
      w1 = (st << 8) | (int'(fdf) << 5) | (int'(brs) << 4) | dlc;
      exp_addr.push_back(a0 + 1);
      exp_data.push_back(w1);
      for (int w = 0; w < (st + 3) / 4; w++) begin
        int d;
        d = 0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < st) d = d | (pbyte(seed, 4 * w + b) << (8 * b));
        exp_addr.push_back(a0 + 2 + w);
        exp_data.push_back(d);
      end
    end
    @(posedge clk); #1;
    hdr_valid = 1'b1; hdr_id = 29'(id); hdr_xtd = xtd; hdr_fdf = fdf;
    hdr_brs = brs; hdr_esi = esi; hdr_dlc = 4'(dlc);
    do begin @(negedge clk); r = hdr_ready; @(posedge clk); end while (!r);
    #1 hdr_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      dat_valid = 1'b1;
      dat_byte = 8'(pbyte(seed, k));
      do begin @(negedge clk); r = dat_ready; @(posedge clk); end while (!r);
      #1;
    end
    dat_valid = 1'b0;
    @(negedge clk);
    while (!hdr_ready) @(negedge clk);
    if (dropped) m_ovr = 1;
    else begin
      m_put = (m_put + 1) % m_count;
      m_fill++;
    end
    check_state(tag);
    chk(tag, "pending writes", exp_addr.size(), 0);
  endtask

  task automatic do_pop(string tag);
    @(posedge clk); #1 pop = 1'b1;
    @(posedge clk); #1 pop = 1'b0;
    if (m_fill > 0) begin
      m_get = (m_get + 1) % m_count;
      m_fill--;
    end
    @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // 8-byte elements, four of them
    start(12'h100, 4, 0);
    send_frame("R5", 29'h123, 0, 0, 0, 0, 3, 1);     // partial word padded with zero
    send_frame("R2", 29'h7FF, 0, 0, 1, 1, 12, 2);    // classic code above 8
    send_frame("R6", 29'h055, 0, 1, 1, 0, 9, 3);     // 12 bytes into 8-byte element
    send_frame("R7", 29'h3A0, 0, 1, 0, 0, 0, 4);     // zero length, queue now full
    send_frame("R8", 29'h111, 0, 0, 0, 0, 5, 5);     // dropped
    send_frame("R8", 29'h112, 0, 1, 0, 0, 0, 6);     // dropped, zero length
    do_pop("R9");
    do_pop("R9");
    send_frame("R7", 29'h200, 0, 0, 0, 1, 8, 7);     // put wraps to 0 -> 1
    do_pop("R9");
    do_pop("R9");
    do_pop("R9");
    do_pop("R9");                                     // empty: ignored

    // 64-byte elements: long codes, extended identifiers
    start(12'h040, 4, 3);
    send_frame("R1", 29'h1ABCDEF0, 1, 1, 1, 0, 15, 11);
    send_frame("R1", 29'h0000_0ABC, 1, 1, 0, 1, 13, 12);
    send_frame("R1", 29'h12345, 1, 1, 1, 1, 11, 13);
    send_frame("R3", 29'h00F, 0, 1, 0, 0, 12, 14);

    // 32-byte elements: truncation of 48
    start(12'h000, 2, 2);
    send_frame("R6", 29'h321, 0, 1, 1, 0, 14, 21);
    send_frame("R1", 29'h322, 0, 1, 1, 0, 10, 22);
    send_frame("R8", 29'h323, 0, 1, 1, 0, 15, 23);

    // 16-byte elements
    start(12'h200, 3, 1);
    send_frame("R4", 29'h0F0F0F0F, 1, 1, 1, 1, 10, 31);
    send_frame("R6", 29'h0AA, 0, 1, 0, 0, 11, 32);

    repeat (4) @(posedge clk);
    chk("R3", "leftover writes", exp_addr.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule